// File: doc/BRIEF.md
# Banked RAM Page Mapper

The page mapper turns a 16-bit CPU address into a 19-bit physical RAM address that spans 512K. The CPU space is cut into four 16K windows, selected by the top two address bits. Each window holds a 5-bit physical page number, so any of 32 physical pages can appear in any window. Software loads and reads these page numbers with I/O cycles. Address bits 9:8 of the I/O cycle pick the window register.

Three inputs change how addresses are translated. A map-mode input picks between the programmable registers and a fixed compatibility map. An address-recode input exchanges two address bits for CPU accesses that land in video memory. A block input bypasses translation completely, so that an external bus master can drive physical addresses itself. A flag output marks accesses that reach the video pages.

Top module: `page_mapper`

## Requirements
- R1: After reset, window register n holds physical page n for n = 0..3 (identity map).
- R2: When io_req and io_wr are both 1 at a rising clock edge, io_wdata[4:0] is stored into the window register selected by cpu_addr[9:8]. Bits io_wdata[7:5] are discarded. The write happens whatever the levels of map_prog and ext_block.
- R3: When map_prog is 1 and ext_block is 0, phys_addr[18:14] equals the register selected by cpu_addr[15:14], and phys_addr[13:0] equals cpu_addr[13:0] unless R7 applies.
- R4: When io_req and io_rd are both 1, io_rdata is {3'b000, register selected by cpu_addr[9:8]}. This read path is combinational and does not depend on map_prog. In every other case io_rdata is 0.
- R5: When map_prog is 0 and ext_block is 0, the page is cpu_addr[15:14] zero-extended to 5 bits. The registers keep their contents and can still be written and read.
- R6: vram_hit is 1 exactly when ext_block is 0 and the selected physical page is below 4.
- R7: When vram_hit and recode_en are both 1, bits 11 and 14 of phys_addr are exchanged. When vram_hit is 0, recode_en has no effect.
- R8: When ext_block is 1, phys_addr is {3'b000, cpu_addr}, vram_hit is 0 and no bits are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes happen on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address; bits 15:14 pick the window on memory cycles, bits 9:8 pick the register on I/O cycles |
| io_req | input | 1 | I/O cycle addressed to the mapper |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | Write data carrying the page number |
| io_rdata | output | 8 | Read-back data |
| map_prog | input | 1 | 1 selects the programmable map, 0 selects the fixed compatibility map |
| recode_en | input | 1 | Enables the bit-11/bit-14 exchange for video accesses |
| ext_block | input | 1 | Bypasses translation for an external bus master |
| phys_addr | output | 19 | Physical RAM address |
| vram_hit | output | 1 | Access falls in physical pages 0 to 3 |

## Verification
The properties assume that io_rd and io_wr are never 1 together. They also assume that cpu_addr and the mode inputs are known and stay steady between falling edges, because the translation path is combinational. The stimulus changes every input only on the falling clock edge and never raises both strobes in the same cycle. Each I/O write is followed directly by a read of the same window, which is the pairing the write property relies on.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
   // Which source drives the physical page for the current access
   typedef enum logic [1:0] {
      SRC_PROG   = 2'd0,
      SRC_COMPAT = 2'd1,
      SRC_BYPASS = 2'd2
   } page_src_e;

   // I/O register index sits at this CPU address bit upward
   localparam int unsigned IO_IDX_LSB = 8;
   // Lower bit of the pair exchanged for recoded video accesses
   localparam int unsigned SWAP_LO    = 11;
endpackage

// File: rtl/pmap_regs.sv
module pmap_regs #(
   parameter int unsigned PAGE_W = 5,
   parameter int unsigned WIN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIN_W-1:0]  wr_idx,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [WIN_W-1:0]  map_idx,
   input  logic [WIN_W-1:0]  rd_idx,
   output logic [PAGE_W-1:0] map_page,
   output logic [PAGE_W-1:0] rd_page
);
   localparam int unsigned NWIN = 1 << WIN_W;

   logic [PAGE_W-1:0] page_q [NWIN];

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            page_q[w] <= PAGE_W'(w);
         else if (wr_en && wr_idx == WIN_W'(w))
            page_q[w] <= wr_page;
      end
   end

   assign map_page = page_q[map_idx];
   assign rd_page  = page_q[rd_idx];
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
   import pmap_pkg::*;
#(
   parameter int unsigned PAGE_W     = 5,
   parameter int unsigned WIN_W      = 2,
   parameter int unsigned OFF_W      = 14,
   parameter int unsigned VRAM_PAGES = 4
) (
   input  page_src_e                 src,
   input  logic [WIN_W+OFF_W-1:0]    cpu_addr,
   input  logic [PAGE_W-1:0]         prog_page,
   input  logic                      recode_en,
   output logic [PAGE_W+OFF_W-1:0]   phys_addr,
   output logic                      vram_hit
);
   localparam int unsigned ADDR_W = WIN_W + OFF_W;
   localparam int unsigned PHYS_W = PAGE_W + OFF_W;

   logic [PAGE_W-1:0] page;
   logic              low_page;
   logic [PHYS_W-1:0] raw;

   always_comb begin
      unique case (src)
         SRC_COMPAT: page = {{(PAGE_W-WIN_W){1'b0}}, cpu_addr[ADDR_W-1 -: WIN_W]};
         default:    page = prog_page;
      endcase
   end

   // Video-page compare: pick the cheaper form when the count is a power of two
   if ((VRAM_PAGES & (VRAM_PAGES - 1)) == 0) begin : g_vram_pow2
      localparam int unsigned VB = $clog2(VRAM_PAGES);
      assign low_page = ~|page[PAGE_W-1:VB];
   end else begin : g_vram_cmp
      assign low_page = page < PAGE_W'(VRAM_PAGES);
   end

   always_comb begin
      if (src == SRC_BYPASS) begin
         raw       = {{(PHYS_W-ADDR_W){1'b0}}, cpu_addr};
         vram_hit  = 1'b0;
         phys_addr = raw;
      end else begin
         raw       = {page, cpu_addr[OFF_W-1:0]};
         vram_hit  = low_page;
         phys_addr = raw;
         if (low_page && recode_en) begin
            phys_addr[SWAP_LO] = raw[OFF_W];
            phys_addr[OFF_W]   = raw[SWAP_LO];
         end
      end
   end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
   import pmap_pkg::*;
#(
   parameter int unsigned PAGE_W     = 5,
   parameter int unsigned WIN_W      = 2,
   parameter int unsigned OFF_W      = 14,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned VRAM_PAGES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WIN_W+OFF_W-1:0]     cpu_addr,
   input  logic                       io_req,
   input  logic                       io_rd,
   input  logic                       io_wr,
   input  logic [DATA_W-1:0]          io_wdata,
   output logic [DATA_W-1:0]          io_rdata,
   input  logic                       map_prog,
   input  logic                       recode_en,
   input  logic                       ext_block,
   output logic [PAGE_W+OFF_W-1:0]    phys_addr,
   output logic                       vram_hit
);
   localparam int unsigned ADDR_W = WIN_W + OFF_W;

   // Elaboration-time parameter checks
   if (DATA_W < PAGE_W)              $error("DATA_W must hold a page number");
   if (PAGE_W < WIN_W)               $error("PAGE_W must cover the window count");
   if (SWAP_LO >= OFF_W)             $error("swap bit must lie inside the window offset");
   if (IO_IDX_LSB + WIN_W > ADDR_W)  $error("I/O index bits exceed the address");
   if (VRAM_PAGES < 2 || VRAM_PAGES % 2 != 0)
                                     $error("VRAM_PAGES must be even and at least 2");
   if (VRAM_PAGES > (1 << PAGE_W))   $error("VRAM_PAGES exceeds the physical page count");

   page_src_e         src;
   logic [PAGE_W-1:0] map_page;
   logic [PAGE_W-1:0] rd_page;
   logic [WIN_W-1:0]  io_idx;

   assign io_idx = cpu_addr[IO_IDX_LSB +: WIN_W];

   always_comb begin
      if (ext_block)     src = SRC_BYPASS;
      else if (map_prog) src = SRC_PROG;
      else               src = SRC_COMPAT;
   end

   pmap_regs #(.PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (io_req && io_wr),
      .wr_idx   (io_idx),
      .wr_page  (io_wdata[PAGE_W-1:0]),
      .map_idx  (cpu_addr[ADDR_W-1 -: WIN_W]),
      .rd_idx   (io_idx),
      .map_page (map_page),
      .rd_page  (rd_page)
   );

   pmap_xlate #(
      .PAGE_W(PAGE_W), .WIN_W(WIN_W), .OFF_W(OFF_W), .VRAM_PAGES(VRAM_PAGES)
   ) u_xlate (
      .src       (src),
      .cpu_addr  (cpu_addr),
      .prog_page (map_page),
      .recode_en (recode_en),
      .phys_addr (phys_addr),
      .vram_hit  (vram_hit)
   );

   assign io_rdata = (io_req && io_rd) ? {{(DATA_W-PAGE_W){1'b0}}, rd_page} : '0;
endmodule

// File: rtl/pmap_chk.sv
module pmap_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic        io_req,
   input logic        io_rd,
   input logic        io_wr,
   input logic [7:0]  io_wdata,
   input logic [7:0]  io_rdata,
   input logic        map_prog,
   input logic        recode_en,
   input logic        ext_block,
   input logic [18:0] phys_addr,
   input logic        vram_hit
);
   // R2
   write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && io_wr && !io_rd) |=>
         (!(io_req && io_rd && cpu_addr[9:8] == $past(cpu_addr[9:8]))
          || io_rdata[4:0] == $past(io_wdata[4:0])));

   // R4
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_req && io_rd) |-> io_rdata == 8'h00);

   // R4
   rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdata[7:5] == 3'b000);

   // R5
   compat_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!map_prog && !ext_block && !recode_en) |-> phys_addr[18:14] == {3'b000, cpu_addr[15:14]});

   // R6
   vram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_block |-> vram_hit == (phys_addr[18:16] == 3'b000));

   // R7
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vram_hit && recode_en) |-> phys_addr[14] == cpu_addr[11]);

   // R7
   no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!recode_en || !vram_hit) |-> phys_addr[13:0] == cpu_addr[13:0]);

   // R8
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_block |-> (phys_addr == {3'b000, cpu_addr} && !vram_hit));
endmodule

bind page_mapper pmap_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .io_req    (io_req),
   .io_rd     (io_rd),
   .io_wr     (io_wr),
   .io_wdata  (io_wdata),
   .io_rdata  (io_rdata),
   .map_prog  (map_prog),
   .recode_en (recode_en),
   .ext_block (ext_block),
   .phys_addr (phys_addr),
   .vram_hit  (vram_hit)
);

// File: tb/page_mapper_test.sv
module page_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        io_req = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        map_prog = 1'b1, recode_en = 1'b0, ext_block = 1'b0;
   logic [18:0] phys_addr;
   logic        vram_hit;

   always #2 clk = ~clk;

   page_mapper uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
      .io_req(io_req), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .map_prog(map_prog), .recode_en(recode_en), .ext_block(ext_block),
      .phys_addr(phys_addr), .vram_hit(vram_hit)
   );

   typedef struct {
      logic [18:0] addr;
      logic        vram;
      logic [7:0]  rdata;
      string       tag;
   } item_t;

   item_t      sb[$];
   logic [4:0] model [4];
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   task automatic drive(input logic [15:0] a, input logic req, input logic rd,
                        input logic wr, input logic [7:0] wd, input logic prog,
                        input logic rec, input logic blk, input string tag);
      item_t       it;
      logic [4:0]  page;
      logic [18:0] raw;
      @(negedge clk);
      cpu_addr = a; io_req = req; io_rd = rd; io_wr = wr; io_wdata = wd;
      map_prog = prog; recode_en = rec; ext_block = blk;
      page = prog ? model[a[15:14]] : {3'b000, a[15:14]};
      if (blk) begin
         it.addr = {3'b000, a};
         it.vram = 1'b0;
      end else begin
         raw     = {page, a[13:0]};
         it.vram = (page < 5'd4);
         it.addr = raw;
         if (it.vram && rec) begin
            it.addr[11] = raw[14];
            it.addr[14] = raw[11];
         end
      end
      it.rdata = (req && rd) ? {3'b000, model[a[9:8]]} : 8'h00;
      it.tag   = tag;
      sb.push_back(it);
      if (req && wr) model[a[9:8]] = wd[4:0];
   endtask

   task automatic io_write(input logic [1:0] w, input logic [7:0] d, input logic prog, input string tag);
      drive({6'b0, w, 8'h00}, 1'b1, 1'b0, 1'b1, d, prog, 1'b0, 1'b0, tag);
   endtask

   task automatic io_read(input logic [1:0] w, input logic prog, input string tag);
      drive({6'b0, w, 8'h00}, 1'b1, 1'b1, 1'b0, 8'h00, prog, 1'b0, 1'b0, tag);
   endtask

   task automatic mem(input logic [15:0] a, input logic prog, input logic rec,
                      input logic blk, input string tag);
      drive(a, 1'b0, 1'b0, 1'b0, 8'h00, prog, rec, blk, tag);
   endtask

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops expected items and compares between edges
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            cmp(it.tag, "phys_addr", 32'(phys_addr), 32'(it.addr));
            cmp(it.tag, "vram_hit",  32'(vram_hit),  32'(it.vram));
            cmp(it.tag, "io_rdata",  32'(io_rdata),  32'(it.rdata));
         end
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model[i] = 5'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: identity after reset, via read-back and translation
      for (int w = 0; w < 4; w++) io_read(2'(w), 1'b1, "R1 reset read");
      mem(16'h4123, 1'b1, 1'b0, 1'b0, "R1 reset map");
      mem(16'hC7FF, 1'b1, 1'b0, 1'b0, "R1 reset map");

      // R2/R4: write then read same window; upper data bits dropped
      io_write(2'd0, 8'h1F, 1'b1, "R2 write w0");
      io_read (2'd0, 1'b1, "R4 read w0");
      io_write(2'd1, 8'hE4, 1'b1, "R2 write w1 upper bits");
      io_read (2'd1, 1'b1, "R4 read w1");
      io_write(2'd2, 8'h02, 1'b1, "R2 write w2");
      io_read (2'd2, 1'b1, "R4 read w2");
      io_write(2'd3, 8'h11, 1'b1, "R2 write w3");
      io_read (2'd3, 1'b1, "R4 read w3");
      // read strobe without io_req returns zero
      drive(16'h0100, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R4 no req");

      // R3: programmable translation through every window
      mem(16'h0ABC, 1'b1, 1'b0, 1'b0, "R3 w0");
      mem(16'h7FFF, 1'b1, 1'b0, 1'b0, "R3 w1");
      mem(16'h8800, 1'b1, 1'b0, 1'b0, "R3 w2");
      mem(16'hF001, 1'b1, 1'b0, 1'b0, "R3 w3");

      // R6: boundary page 3 vs 4
      io_write(2'd1, 8'h03, 1'b1, "R6 set page 3");
      io_read (2'd1, 1'b1, "R6 read page 3");
      mem(16'h4000, 1'b1, 1'b0, 1'b0, "R6 page 3 hit");
      io_write(2'd1, 8'h04, 1'b1, "R6 set page 4");
      io_read (2'd1, 1'b1, "R6 read page 4");
      mem(16'h4000, 1'b1, 1'b0, 1'b0, "R6 page 4 miss");

      // R7: recode swaps bits 11 and 14 only on video pages
      mem(16'h8800, 1'b1, 1'b1, 1'b0, "R7 swap page 2 a11=1");
      io_write(2'd2, 8'h01, 1'b1, "R7 set page 1");
      io_read (2'd2, 1'b1, "R7 read page 1");
      mem(16'h8123, 1'b1, 1'b1, 1'b0, "R7 swap page 1 a11=0");
      mem(16'h4800, 1'b1, 1'b1, 1'b0, "R7 no swap page 4");
      mem(16'hF800, 1'b1, 1'b1, 1'b0, "R7 no swap page 17");

      // R5: compatibility map ignores registers, still writable
      mem(16'h0ABC, 1'b0, 1'b0, 1'b0, "R5 compat w0");
      mem(16'hC800, 1'b0, 1'b0, 1'b0, "R5 compat w3");
      mem(16'hC800, 1'b0, 1'b1, 1'b0, "R5 compat recode");
      io_write(2'd3, 8'h09, 1'b0, "R5 write in compat");
      io_read (2'd3, 1'b0, "R5 read in compat");
      mem(16'hC000, 1'b0, 1'b0, 1'b0, "R5 compat after write");
      mem(16'hC000, 1'b1, 1'b0, 1'b0, "R5 prog after compat write");

      // R8: block bypasses translation and swap
      mem(16'hF800, 1'b1, 1'b1, 1'b1, "R8 block");
      mem(16'h0800, 1'b1, 1'b1, 1'b1, "R8 block video");
      mem(16'h0800, 1'b0, 1'b0, 1'b1, "R8 block compat");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule